// File: doc/BRIEF.md
# Padded AEAD Message Assembler

This block assembles the authentication string that a synthetic-IV authenticated cipher feeds to its hash. A transfer starts with a configuration handshake that carries the byte lengths of the associated data and of the message. The bytes of both fields then arrive on one byte-wide stream: associated data first, then message. Each non-empty field closes with its own last flag.

The assembler writes every byte into a 64-byte block buffer. It zero-fills the associated data out to a whole block and zero-fills the message out to the next 16-byte boundary. It then adds two 64-bit little-endian length words: associated-data length first, message length second. Finished blocks leave through a valid/ready port. The closing block carries a last flag and a 2-bit code that tells the downstream hash how many 16-byte lanes of that block hold data.

Only one block is held at a time. While it waits for the consumer, the byte input is stalled.

Top module: `aead_msg_assembler`

## Requirements
- R1: After reset, out_valid and in_ready are low and cfg_ready is high.
- R2: Associated-data byte k lands in byte lane k mod 64 of its block, where lane j is out_data[8j+7:8j]. The field is zero-padded up to a multiple of 64 bytes, and each of its blocks is emitted with out_last low.
- R3: The message starts right after the padded associated data, in the same byte order. It is zero-padded up to a multiple of 16 bytes.
- R4: After the padded message come two 8-byte fields: the associated-data length, then the message length. Both are little-endian and zero-extended from the configured counts. If the padded message fills its block exactly, the length fields open a new block.
- R5: The final block has out_last high and out_mode = (valid bytes / 16) - 1, so 0 means 16 bytes and 3 means 64. Every byte lane above the valid region is zero. On blocks that are not last, out_mode is 0.
- R6: A zero-length field adds no bytes and expects no stream bytes. When both fields are empty, the output is one last block holding only the length fields, with mode 0.
- R7: A field ends on the stream byte flagged in_last. The configured counts set only the length words and mark which fields are empty.
- R8: While out_valid is high and out_ready is low, out_data, out_last and out_mode hold steady and in_ready stays low.
- R9: A configuration is taken only when cfg_ready is high. A cfg_valid pulse during a transfer is ignored and does not change the length words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Start request carrying the two lengths |
| cfg_ad_len | input | LEN_W | Associated-data byte count |
| cfg_msg_len | input | LEN_W | Message byte count |
| cfg_ready | output | 1 | Idle with no block pending; a start can be taken |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of the current field |
| in_ready | output | 1 | Stream byte can be taken |
| out_valid | output | 1 | Block valid |
| out_ready | input | 1 | Consumer takes the block |
| out_data | output | 512 | Block, stream byte 0 in bits 7:0 |
| out_last | output | 1 | Final block of the assembly |
| out_mode | output | 2 | Final-block fill in 16-byte lanes, minus one |

## Verification
The bench targets several boundary cases.

- An associated-data field of exactly 64 bytes: an extra padding block would show up here.
- A 48-byte message: the length words must fit in the same block, giving mode 3.
- A 49-byte message: the length words must spill into a fresh block with mode 0. A padding rule that got the rounding wrong would emit the wrong number of blocks or a wrong mode.
- Empty fields: a design that expected a byte for an empty field would hang.

Randomly timed out_ready stalls check that a held block does not change and that no input byte slips into it. Stray start pulses sent mid-transfer would corrupt the length words if they were accepted.

// File: rtl/aead_msg_assembler.sv
module aead_msg_assembler #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [LEN_W-1:0] cfg_ad_len,
  input  logic [LEN_W-1:0] cfg_msg_len,
  output logic             cfg_ready,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [511:0]     out_data,
  output logic             out_last,
  output logic [1:0]       out_mode
);
  localparam int BLK_W = 512;

  typedef enum logic [1:0] {S_IDLE, S_AD, S_MSG, S_LEN} state_t;

  state_t             state;
  logic [5:0]         ptr;
  logic [BLK_W-1:0]   blk;
  logic [LEN_W-1:0]   ad_len_q, msg_len_q;

  logic in_fire;
  assign cfg_ready = (state == S_IDLE) && !out_valid;
  assign in_ready  = ((state == S_AD) || (state == S_MSG)) && !out_valid;
  assign in_fire   = in_valid && in_ready;
  assign out_data  = blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      blk       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_mode  <= 2'd0;
      ad_len_q  <= '0;
      msg_len_q <= '0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
        out_mode  <= 2'd0;
        blk       <= '0;
      end
      case (state)
        S_IDLE: if (cfg_valid && cfg_ready) begin
          ad_len_q  <= cfg_ad_len;
          msg_len_q <= cfg_msg_len;
          ptr       <= '0;
          if (cfg_ad_len != '0)       state <= S_AD;
          else if (cfg_msg_len != '0) state <= S_MSG;
          else                        state <= S_LEN;
        end
        S_AD: if (in_fire) begin
          blk[{ptr, 3'b000} +: 8] <= in_data;
          ptr <= ptr + 6'd1;
          if (in_last || ptr == 6'd63) begin
            out_valid <= 1'b1;
            ptr       <= '0;
          end
          if (in_last) state <= (msg_len_q != '0) ? S_MSG : S_LEN;
        end
        S_MSG: if (in_fire) begin
          blk[{ptr, 3'b000} +: 8] <= in_data;
          ptr <= ptr + 6'd1;
          if (ptr == 6'd63) out_valid <= 1'b1;
          if (in_last) begin
            state <= S_LEN;
            if (ptr[5:4] == 2'd3) begin
              out_valid <= 1'b1;
              ptr       <= '0;
            end else begin
              ptr <= {ptr[5:4] + 2'd1, 4'b0000};
            end
          end
        end
        S_LEN: if (!out_valid) begin
          blk[{ptr[5:4], 7'b0000000} +: 128] <= {64'(msg_len_q), 64'(ad_len_q)};
          out_valid <= 1'b1;
          out_last  <= 1'b1;
          out_mode  <= ptr[5:4];
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_mode) && !in_ready);

  a_r5_mode_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_mode == 2'd0);

  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_data >> ({1'b0, out_mode, 7'b0000000} + 10'd128)) == '0);

  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> !cfg_ready);
endmodule

// File: tb/aead_msg_assembler_tb.sv
module aead_msg_assembler_tb;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [LEN_W-1:0] cfg_ad_len = '0, cfg_msg_len = '0;
  logic cfg_ready;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid, out_last;
  logic out_ready = 1'b0;
  logic [511:0] out_data;
  logic [1:0] out_mode;

  always #10 clk = ~clk;

  aead_msg_assembler #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ad_len(cfg_ad_len),
    .cfg_msg_len(cfg_msg_len), .cfg_ready(cfg_ready), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_mode(out_mode));

  int checks = 0, fails = 0;
  bit hung = 0;
  logic [7:0] ad_b [0:255];
  logic [7:0] msg_b [0:255];
  logic [7:0] exp_b [0:1023];

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(int alen, int mlen, int rdy_pct, int vld_pct, bit poke);
    int pos, total, nblk, lastb, emode, idx, tot, got, guard;
    bit held;
    logic [511:0] held_data, ev;
    for (int i = 0; i < alen; i++) ad_b[i] = 8'($urandom);
    for (int i = 0; i < mlen; i++) msg_b[i] = 8'($urandom);
    for (int i = 0; i < 1024; i++) exp_b[i] = 8'h00;
    pos = 0;
    for (int i = 0; i < alen; i++) exp_b[i] = ad_b[i];
    pos = ((alen + 63) / 64) * 64;
    for (int i = 0; i < mlen; i++) exp_b[pos + i] = msg_b[i];
    pos += ((mlen + 15) / 16) * 16;
    for (int i = 0; i < 8; i++) exp_b[pos + i] = 8'((64'(alen)) >> (8 * i));
    for (int i = 0; i < 8; i++) exp_b[pos + 8 + i] = 8'((64'(mlen)) >> (8 * i));
    total = pos + 16;
    nblk = (total + 63) / 64;
    lastb = total - 64 * (nblk - 1);
    emode = lastb / 16 - 1;

    guard = 0;
    while (!cfg_ready && guard < 1000) begin @(negedge clk); guard++; end
    chk(cfg_ready, "R9", "cfg_ready before start", 512'(cfg_ready), 512'(1));
    cfg_valid = 1'b1; cfg_ad_len = LEN_W'(alen); cfg_msg_len = LEN_W'(mlen);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(!cfg_ready, "R9", "cfg_ready after start", 512'(cfg_ready), 512'(0));

    tot = alen + mlen; idx = 0; got = 0; guard = 0; held = 0; held_data = '0;
    while (got < nblk) begin
      if (guard > 5000) begin
        hung = 1;
        chk(0, "R7", "watchdog expired", 512'(got), 512'(nblk));
        break;
      end
      guard++;
      if (held) begin
        chk(out_valid && out_data == held_data && !in_ready, "R8", "held block changed",
            out_data, held_data);
        held = 0;
      end
      in_valid = (idx < tot) && (($urandom % 100) < vld_pct);
      in_data  = (idx < alen) ? ad_b[idx] : msg_b[(idx - alen) & 255];
      in_last  = (alen > 0 && idx == alen - 1) || (mlen > 0 && idx == tot - 1);
      out_ready = ($urandom % 100) < rdy_pct;
      if (poke) begin
        cfg_valid = ($urandom % 4) == 0;
        cfg_ad_len = LEN_W'($urandom); cfg_msg_len = LEN_W'($urandom);
      end
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        for (int b = 0; b < 64; b++) ev[b*8 +: 8] = exp_b[got*64 + b];
        chk(out_data == ev, (got == nblk - 1) ? "R4" : "R2", "block data", out_data, ev);
        chk(out_last == (got == nblk - 1), "R5", "last flag", 512'(out_last), 512'(got == nblk - 1));
        chk(out_mode == ((got == nblk - 1) ? 2'(emode) : 2'd0), "R5", "mode",
            512'(out_mode), 512'((got == nblk - 1) ? emode : 0));
        got++;
      end else if (out_valid) begin
        held = 1; held_data = out_data;
      end
      @(negedge clk);
    end
    in_valid = 0; in_last = 0; out_ready = 0; cfg_valid = 0;
    @(negedge clk);
    chk(!out_valid, "R6", "no extra block", 512'(out_valid), 512'(0));
    chk(idx == tot, "R7", "bytes consumed", 512'(idx), 512'(tot));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready && cfg_ready, "R1", "reset outputs",
        512'({out_valid, in_ready, cfg_ready}), 512'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    run_case(0, 0, 100, 100, 0);     // R6 both empty
    run_case(64, 0, 100, 100, 0);    // R2 exact block
    run_case(0, 48, 100, 100, 0);    // R5 mode 3
    run_case(0, 49, 100, 100, 0);    // R4 spill
    run_case(3, 5, 50, 60, 0);       // R3
    run_case(65, 17, 40, 70, 1);     // R9 pokes
    run_case(1, 0, 100, 100, 0);
    run_case(0, 1, 30, 100, 0);      // R8
    run_case(128, 63, 60, 80, 1);
    for (int n = 0; n < 20 && !hung; n++)
      run_case(int'($urandom % 201), int'($urandom % 201),
               20 + int'($urandom % 81), 20 + int'($urandom % 81), n[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule